// File: doc/BRIEF.md
# Reset Controller with Cause Capture

This block merges every reset request in a subsystem into a single synchronous, active-high system reset. Four kinds of request feed it: an active-low board pin, a power-on indication, a software request made by a keyed register write, and a watchdog expiry that can be masked. A fifth input carries reset requests from a companion domain, which are counted as external resets. Once any request is seen, the reset output is held for a fixed number of cycles after the last request goes away. It is then released on a clock edge.

Software finds out why the last reset happened by reading a six-bit cause register over a simple single-cycle register bus. The cause bits are sticky. Only a power-on event or a write-one-to-clear access from software clears them, so the record survives every other kind of reset. A power-on event also records a two-bit sub-code taken from the power-on source.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While any accepted request is active (power-on, filtered pin, companion request, enabled watchdog, valid software write), `sys_rst_o` is 1 on the following clock cycle.
- R2: After the last accepted request is released, `sys_rst_o` stays 1 for exactly STRETCH_CYCLES (default 16) cycles and then drops to 0.
- R3: The pin `ext_rst_ni` passes through a two-flop synchroniser. It counts as a request only when two consecutive synchronised samples are low, so a low pulse of one clock is ignored.
- R4: The cause register is read at STATUS_ADDR (default 0x0) in `bus_rdata_o` bits [5:0], with all other bits 0. The bits are: 0 = power-on, 1 = external (pin or companion), 2 = watchdog, 3 = software, [5:4] = power-on sub-code. Any other address reads 0.
- R5: A power-on request clears every cause bit, sets bit 0 and loads bits [5:4] from `por_code_i`.
- R6: Cause bits are sticky: a non-power-on reset only sets its own bit and never clears any other bit.
- R7: A write to STATUS_ADDR clears each cause bit whose write-data bit is 1 and leaves the others unchanged. If a cause is set in the same cycle, setting wins.
- R8: A software reset fires only on a write to SWRST_ADDR (default 0xE000ED0C) whose data has 0x05FA in bits [31:16] and 1 in bit 2. Such a write sets cause bit 3.
- R9: A write to SWRST_ADDR with a wrong key, or with bit 2 clear, has no effect: no reset and no change to the cause register.
- R10: When `wdt_en_i` is 0, `wdt_expire_i` is ignored: no reset and cause bit 2 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on indication, active high, synchronous |
| por_code_i | input | 2 | Power-on sub-cause, captured while `por_i` is high |
| ext_rst_ni | input | 1 | Asynchronous external reset pin, active low |
| comp_rst_i | input | 1 | Reset request from the companion domain |
| wdt_expire_i | input | 1 | Watchdog expiry request |
| wdt_en_i | input | 1 | Enables the watchdog as a reset source |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 32 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from `bus_addr_i` |
| sys_rst_o | output | 1 | Stretched synchronous system reset, active high |

## Verification
The bench builds the block with its default parameters: a 16-cycle stretch, two synchroniser stages, a two-sample pin filter, the status register at address 0 and the keyed request register at 0xE000ED0C. These values make the stretch length exactly countable at the ports. The one-cycle and two-cycle pin pulses fall directly on the filter boundary. Keys that differ from the correct key by a single bit, and writes with the request bit missing, are directed cases. A seeded random mix then interleaves all the sources with partial write-one-to-clear masks against a bench model of the cause register.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int CAUSE_W = 6;

    typedef struct packed {
        logic [1:0] por_code;
        logic       sw;
        logic       wdt;
        logic       ext;
        logic       por;
    } cause_t;

    typedef struct packed {
        logic por;
        logic ext;
        logic wdt;
        logic sw;
    } req_t;

    function automatic logic key_match(input logic [15:0] got, input logic [15:0] want);
        return got == want;
    endfunction

    function automatic logic req_any(input req_t r);
        return r.por | r.ext | r.wdt | r.sw;
    endfunction

endpackage

// File: rtl/rstc_pin_sync.sv
module rstc_pin_sync #(
    parameter int STAGES = 2,
    parameter int FILT   = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic req
);
    logic [STAGES-1:0] sync_q;
    logic [FILT-1:0]   low_hist_q;

    always_ff @(posedge clk) begin
        sync_q <= {sync_q[STAGES-2:0], pin_n};
    end

    generate
        if (FILT == 1) begin : g_nofilt
            always_ff @(posedge clk) low_hist_q <= ~sync_q[STAGES-1];
        end else begin : g_filt
            always_ff @(posedge clk)
                low_hist_q <= {low_hist_q[FILT-2:0], ~sync_q[STAGES-1]};
        end
    endgenerate

    assign req = &low_hist_q;
endmodule

// File: rtl/rstc_swreq.sv
module rstc_swreq
    import rstc_pkg::*;
#(
    parameter int              ADDR_W  = 32,
    parameter int              DATA_W  = 32,
    parameter logic [ADDR_W-1:0] SW_ADDR = 32'hE000_ED0C,
    parameter logic [15:0]     KEY     = 16'h05FA,
    parameter int              REQ_BIT = 2
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              sw_req
);
    always_comb begin
        sw_req = we && (addr == SW_ADDR)
              && key_match(wdata[DATA_W-1 -: 16], KEY)
              && wdata[REQ_BIT];
    end
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic req,
    output logic rst_out
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (req)
            cnt_q <= LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign rst_out = (cnt_q != '0);
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause
    import rstc_pkg::*;
(
    input  logic               clk,
    input  req_t               ev,
    input  logic [1:0]         por_code,
    input  logic               clr_we,
    input  logic [CAUSE_W-1:0] clr_mask,
    output cause_t             status
);
    cause_t status_q;
    cause_t set_v;

    always_comb begin
        set_v          = '0;
        set_v.ext      = ev.ext;
        set_v.wdt      = ev.wdt;
        set_v.sw       = ev.sw;
    end

    always_ff @(posedge clk) begin
        if (ev.por) begin
            status_q          <= '0;
            status_q.por      <= 1'b1;
            status_q.por_code <= por_code;
        end else begin
            status_q <= (status_q & ~(clr_we ? cause_t'(clr_mask) : cause_t'('0))) | set_v;
        end
    end

    assign status = status_q;
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
    import rstc_pkg::*;
#(
    parameter int                STRETCH_CYCLES = 16,
    parameter int                SYNC_STAGES    = 2,
    parameter int                PIN_FILT       = 2,
    parameter logic [31:0]       STATUS_ADDR    = 32'h0000_0000,
    parameter logic [31:0]       SWRST_ADDR     = 32'hE000_ED0C,
    parameter logic [15:0]       SW_KEY         = 16'h05FA,
    parameter int                SW_REQ_BIT     = 2
) (
    input  logic        clk,
    input  logic        por_i,
    input  logic [1:0]  por_code_i,
    input  logic        ext_rst_ni,
    input  logic        comp_rst_i,
    input  logic        wdt_expire_i,
    input  logic        wdt_en_i,
    input  logic        bus_we_i,
    input  logic [31:0] bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        sys_rst_o
);
    logic   pin_req;
    logic   sw_req;
    logic   any_req;
    req_t   reqs;
    cause_t status_q;

    rstc_pin_sync #(.STAGES(SYNC_STAGES), .FILT(PIN_FILT)) u_pin (
        .clk   (clk),
        .pin_n (ext_rst_ni),
        .req   (pin_req)
    );

    rstc_swreq #(
        .ADDR_W(32), .DATA_W(32), .SW_ADDR(SWRST_ADDR),
        .KEY(SW_KEY), .REQ_BIT(SW_REQ_BIT)
    ) u_sw (
        .we     (bus_we_i),
        .addr   (bus_addr_i),
        .wdata  (bus_wdata_i),
        .sw_req (sw_req)
    );

    always_comb begin
        reqs.por = por_i;
        reqs.ext = pin_req | comp_rst_i;
        reqs.wdt = wdt_expire_i & wdt_en_i;
        reqs.sw  = sw_req;
        any_req  = req_any(reqs);
    end

    rstc_stretch #(.CYCLES(STRETCH_CYCLES)) u_str (
        .clk     (clk),
        .req     (any_req),
        .rst_out (sys_rst_o)
    );

    rstc_cause u_cause (
        .clk      (clk),
        .ev       (reqs),
        .por_code (por_code_i),
        .clr_we   (bus_we_i && (bus_addr_i == STATUS_ADDR)),
        .clr_mask (bus_wdata_i[CAUSE_W-1:0]),
        .status   (status_q)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == STATUS_ADDR)
            bus_rdata_o[CAUSE_W-1:0] = status_q;
    end
endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk
    import rstc_pkg::*;
#(
    parameter logic [31:0] SWRST_ADDR = 32'hE000_ED0C,
    parameter logic [15:0] SW_KEY     = 16'h05FA
) (
    input logic        clk,
    input logic        por_i,
    input logic [1:0]  por_code_i,
    input logic        wdt_expire_i,
    input logic        wdt_en_i,
    input logic        comp_rst_i,
    input logic        bus_we_i,
    input logic [31:0] bus_addr_i,
    input logic [31:0] bus_wdata_i,
    input logic        any_req,
    input logic        sys_rst_o,
    input cause_t      status_q
);
    assert_req_gives_rst_R1: assert property (@(posedge clk) disable iff (por_i)
        any_req |=> sys_rst_o);

    assert_release_after_quiet_R2: assert property (@(posedge clk) disable iff (por_i)
        $fell(sys_rst_o) |-> !$past(any_req));

    assert_por_load_R5: assert property (@(posedge clk)
        por_i |=> (status_q.por && !status_q.ext && !status_q.wdt && !status_q.sw
                   && status_q.por_code == $past(por_code_i)));

    assert_sw_sets_R8: assert property (@(posedge clk) disable iff (por_i)
        (bus_we_i && bus_addr_i == SWRST_ADDR && bus_wdata_i[31:16] == SW_KEY && bus_wdata_i[2])
        |=> status_q.sw);

    assert_badkey_ignored_R9: assert property (@(posedge clk) disable iff (por_i)
        (bus_we_i && bus_addr_i == SWRST_ADDR && bus_wdata_i[31:16] != SW_KEY)
        |=> status_q.sw == $past(status_q.sw));

    assert_wdt_masked_R10: assert property (@(posedge clk) disable iff (por_i)
        (!wdt_en_i && !(bus_we_i && bus_wdata_i[2]))
        |=> status_q.wdt == $past(status_q.wdt));

    assert_comp_sets_ext_R6: assert property (@(posedge clk) disable iff (por_i)
        comp_rst_i |=> status_q.ext);
endmodule

bind rst_cause_ctrl rst_cause_chk #(.SWRST_ADDR(SWRST_ADDR), .SW_KEY(SW_KEY)) u_chk (
    .clk          (clk),
    .por_i        (por_i),
    .por_code_i   (por_code_i),
    .wdt_expire_i (wdt_expire_i),
    .wdt_en_i     (wdt_en_i),
    .comp_rst_i   (comp_rst_i),
    .bus_we_i     (bus_we_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .any_req      (any_req),
    .sys_rst_o    (sys_rst_o),
    .status_q     (status_q)
);

// File: tb/rst_cause_ctrl_tb.sv
module rst_cause_ctrl_tb;
    localparam logic [31:0] ST_A = 32'h0;
    localparam logic [31:0] SW_A = 32'hE000_ED0C;

    logic        clk = 0;
    logic        por_i = 1;
    logic [1:0]  por_code_i = 2'd2;
    logic        ext_rst_ni = 1;
    logic        comp_rst_i = 0;
    logic        wdt_expire_i = 0;
    logic        wdt_en_i = 1;
    logic        bus_we_i = 0;
    logic [31:0] bus_addr_i = 32'h1234;
    logic [31:0] bus_wdata_i = 0;
    logic [31:0] bus_rdata_o;
    logic        sys_rst_o;

    int checks = 0, fails = 0;
    logic [5:0] model;
    bit done = 0;

    always #5 clk = ~clk;

    rst_cause_ctrl u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_status(input string req);
        bus_addr_i = ST_A;
        #1;
        chk(req, bus_rdata_o, {26'd0, model});
        bus_addr_i = 32'h1234;
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_we_i = 0; bus_addr_i = 32'h1234; bus_wdata_i = 0;
    endtask

    task automatic settle();
        repeat (24) @(negedge clk);
    endtask

    function automatic logic [5:0] w1c(input logic [5:0] s, input logic [5:0] m);
        return s & ~m;
    endfunction

    task automatic pin_pulse(input int n);
        ext_rst_ni = 0;
        repeat (n) @(negedge clk);
        ext_rst_ni = 1;
    endtask

    initial begin
        int seed = 7;
        int cnt;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        por_i = 0;
        @(negedge clk);
        model = 6'b10_0001;
        // R5 R4: power-on state
        chk("R1 rst after por", sys_rst_o, 1);
        read_status("R5 por load");
        bus_addr_i = 32'h55; #1;
        chk("R4 other addr reads 0", bus_rdata_o, 0);
        settle();
        chk("R2 released", sys_rst_o, 0);

        // R2: exact stretch length
        comp_rst_i = 1; @(posedge clk); @(negedge clk); comp_rst_i = 0;
        cnt = 0;
        while (sys_rst_o && cnt < 40) begin cnt++; @(negedge clk); end
        chk("R2 stretch length", cnt, 16);
        model[1] = 1;
        read_status("R6 companion logged as ext");

        // R7: partial W1C
        bus_write(ST_A, 32'h0000_0002);
        model = w1c(model, 6'h02);
        read_status("R7 w1c partial");

        // R3: 1-cycle pin pulse ignored, 2-cycle accepted
        pin_pulse(1); settle();
        chk("R3 short pulse no rst", sys_rst_o, 0);
        read_status("R3 short pulse no cause");
        pin_pulse(2); repeat (4) @(negedge clk);
        chk("R3 two-cycle pulse rst", sys_rst_o, 1);
        model[1] = 1; settle();
        read_status("R3 two-cycle pulse cause");

        // R9: bad keys / missing bit
        bus_write(SW_A, 32'h05FB_0004); @(negedge clk);
        chk("R9 bad key no rst", sys_rst_o, 0);
        bus_write(SW_A, 32'h05FA_0000); @(negedge clk);
        chk("R9 no req bit no rst", sys_rst_o, 0);
        read_status("R9 status unchanged");

        // R8: good key
        bus_write(SW_A, 32'h05FA_0004);
        chk("R8 sw rst", sys_rst_o, 1);
        model[3] = 1; settle();
        read_status("R8 sw cause");

        // R10: watchdog masked, then enabled
        wdt_en_i = 0; wdt_expire_i = 1; @(negedge clk); wdt_expire_i = 0; @(negedge clk);
        chk("R10 masked wdt no rst", sys_rst_o, 0);
        read_status("R10 masked wdt no cause");
        wdt_en_i = 1; wdt_expire_i = 1; @(negedge clk); wdt_expire_i = 0;
        chk("R1 wdt rst", sys_rst_o, 1);
        model[2] = 1; settle();
        read_status("R6 all sticky bits");

        // R7: clear-vs-set same cycle (set wins)
        comp_rst_i = 1; bus_write(ST_A, 32'h3F); comp_rst_i = 0;
        model = 6'b00_0010; settle();
        read_status("R7 set wins over clear");

        // R5: POR wipes with new code
        por_code_i = 2'd1; por_i = 1; @(negedge clk); por_i = 0;
        model = 6'b01_0001; read_status("R5 por wipes");
        settle();

        // random mix
        for (int i = 0; i < 60; i++) begin
            int k = $urandom_range(0, 5);
            case (k)
                0: begin comp_rst_i = 1; @(negedge clk); comp_rst_i = 0; model[1] = 1; end
                1: begin pin_pulse($urandom_range(2, 4)); model[1] = 1; end
                2: begin
                    logic en = 1'($urandom_range(0, 1));
                    wdt_en_i = en; wdt_expire_i = 1; @(negedge clk); wdt_expire_i = 0;
                    if (en) model[2] = 1;
                    wdt_en_i = 1;
                end
                3: begin
                    logic good = 1'($urandom_range(0, 1));
                    bus_write(SW_A, {good ? 16'h05FA : 16'(16'h05FA ^ (1 << $urandom_range(0, 15))), 16'h0004});
                    if (good) model[3] = 1;
                end
                4: begin
                    logic [5:0] m = 6'($urandom);
                    bus_write(ST_A, {26'd0, m}); model = w1c(model, m);
                end
                default: begin
                    logic [1:0] c = 2'($urandom);
                    por_code_i = c; por_i = 1; @(negedge clk); por_i = 0;
                    model = {c, 4'b0001};
                end
            endcase
            settle();
            chk("R2 quiet after random", sys_rst_o, 0);
            read_status("R6 R7 random status");
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin repeat (100000) @(posedge clk); checks++; fails++;
                  $display("FAIL watchdog timeout actual=1 expected=0"); end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule